// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block is the slave end of a two-channel serial audio link. It takes a word clock, a bit clock and a serial data line from an external source, and samples all three with the system clock. It turns the bit stream into parallel signed samples, one for the left channel and one for the right, and gives each a one-cycle valid strobe.

Three static configuration inputs set how the bits are read:

- the framing style: I2S, left-justified or right-justified;
- the bit order;
- the word width.

A received word narrower than the output is placed at the top of the output, so the sign stays correct and the unused low bits read zero. The configuration is meant to be set while the receiver is held in reset and kept steady while it runs.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted and after it is released, `left_sample` and `right_sample` read zero and both valid strobes are low until a complete word has been received.
- R2: With `fmt_sel` = 0 (I2S), the first data bit of a word is the one sampled on the second rising bit-clock edge after the word clock changes level. A word sent while the word clock is low is a left sample.
- R3: With `fmt_sel` = 1 (left-justified), the first data bit of a word is the one sampled on the first rising bit-clock edge after the word clock changes level. A word sent while the word clock is high is a left sample.
- R4: With `fmt_sel` = 2 (right-justified), the last data bit of a word is the one sampled on the final rising bit-clock edge before the word clock changes level. Bits that come before the word in the same half-frame are discarded. A word sent while the word clock is high is a left sample, and it is delivered after the word-clock change that ends it.
- R5: `width_sel` selects the word width: 0 is 24 bits, 1 is 20 bits, 2 is 18 bits, 3 is 16 bits. The received word appears in the upper bits of the 24-bit output, and every bit below it is zero.
- R6: With `lsb_first` = 0 the first data bit of a word is its most significant bit. With `lsb_first` = 1 the first data bit is its least significant bit.
- R7: Serial data and word clock are sampled only on rising bit-clock edges. A change of serial data while the bit clock is high has no effect on the received sample.
- R8: Each valid strobe is a single system-clock pulse, and the two strobes are never high in the same cycle. In every frame exactly one left sample is delivered, followed by one right sample.
- R9: Bits received after reset and before the first word-clock level change produce no output. A right-justified receiver also produces no output at that first change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all three serial inputs are sampled with it |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_clk | input | 1 | Channel-select / framing clock from the source |
| bit_clk | input | 1 | Serial bit clock from the source; rising edge is the active edge |
| ser_data | input | 1 | Serial audio data |
| fmt_sel | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified |
| lsb_first | input | 1 | 0 MSB first, 1 LSB first |
| width_sel | input | 2 | Word width: 0 24, 1 20, 2 18, 3 16 bits |
| left_sample | output | 24 | Last left sample, left-aligned, signed |
| left_valid | output | 1 | One-cycle strobe when `left_sample` is updated |
| right_sample | output | 24 | Last right sample, left-aligned, signed |
| right_valid | output | 1 | One-cycle strobe when `right_sample` is updated |

## Verification
The assertions check on every cycle:

- each strobe is a single pulse and the two strobes are exclusive;
- a delivered sample never carries set bits below the selected width;
- the bit counter and the shift window change only on a detected rising bit-clock edge.

Bit positions relative to the word-clock change cannot be seen in any single cycle, so the bench scenarios are what show them: the I2S one-bit delay, the left-justified start and the right-justified alignment against the frame end. The scenarios also cover channel polarity per framing, both bit orders, each width, suppression of the partial words after reset, and immunity to data changes while the bit clock is high.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

   typedef enum logic [1:0] {
      FMT_I2S   = 2'd0,
      FMT_LEFT  = 2'd1,
      FMT_RIGHT = 2'd2,
      FMT_RSVD  = 2'd3
   } frame_fmt_e;

   // word width selected by the two-bit width code
   function automatic int unsigned word_bits(input logic [1:0] sel);
      case (sel)
         2'd0:    return 24;
         2'd1:    return 20;
         2'd2:    return 18;
         default: return 16;
      endcase
   endfunction

endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
   parameter int STAGES = 2,
   parameter int N      = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sarx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][N-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/sarx_deframe.sv
module sarx_deframe
   import sarx_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int CNT_W    = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bclk,
   input  logic                ws,
   input  logic                sd,
   input  logic [1:0]          fmt,
   input  logic                lsb_first,
   input  logic [1:0]          wsel,
   output logic                emit,
   output logic                emit_left,
   output logic [SAMPLE_W-1:0] word
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (CNT_MAX <= SAMPLE_W) begin : g_bad_cnt
      $error("sarx_deframe: CNT_W too small for SAMPLE_W");
   end

   logic bclk_q, primed, synced, ws_q, chan_left;
   logic rise, ws_edge, is_i2s, is_rj, take, emit_c, left_c;
   logic [CNT_W-1:0]    cnt, wlen;
   logic [SAMPLE_W-1:0] win, win_nx, word_c;

   assign wlen = CNT_W'(word_bits(wsel));

   always_comb begin
      rise    = bclk & ~bclk_q;
      ws_edge = rise && primed && (ws != ws_q);
      is_i2s  = (fmt == FMT_I2S);
      is_rj   = (fmt == FMT_RIGHT);
      win_nx  = lsb_first ? {sd, win[SAMPLE_W-1:1]} : {win[SAMPLE_W-2:0], sd};
      take    = 1'b0;
      emit_c  = 1'b0;
      left_c  = chan_left;
      word_c  = win_nx;
      if (rise) begin
         if (is_rj) begin
            // sliding window: a word ends where the word clock flips
            take = 1'b1;
            if (ws_edge && synced && (cnt >= wlen)) begin
               emit_c = 1'b1;
               left_c = ws_q;
               word_c = win;
            end
         end else if (ws_edge) begin
            take = !is_i2s;
         end else if (synced && (cnt < wlen)) begin
            take   = 1'b1;
            emit_c = (cnt == wlen - 1'b1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_q    <= 1'b0;
         primed    <= 1'b0;
         synced    <= 1'b0;
         ws_q      <= 1'b0;
         chan_left <= 1'b0;
         cnt       <= CNT_MAX;
         win       <= '0;
         emit      <= 1'b0;
         emit_left <= 1'b0;
         word      <= '0;
      end else begin
         bclk_q <= bclk;
         emit   <= emit_c;
         if (emit_c) begin
            emit_left <= left_c;
            word      <= word_c;
         end
         if (rise) begin
            primed <= 1'b1;
            ws_q   <= ws;
            if (take) win <= win_nx;
            if (ws_edge) begin
               synced    <= 1'b1;
               cnt       <= is_i2s ? '0 : CNT_W'(1);
               chan_left <= is_i2s ? ~ws : ws;
            end else if (cnt != CNT_MAX) begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rise |=> $stable(cnt)) else $error("cnt moved without bit-clock edge"); // R7
   AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rise |=> $stable(win)) else $error("window moved without bit-clock edge"); // R7

endmodule

// File: rtl/sarx_align.sv
module sarx_align
   import sarx_pkg::*;
#(
   parameter int SAMPLE_W = 24
) (
   input  logic [SAMPLE_W-1:0] word,
   input  logic [1:0]          wsel,
   input  logic                lsb_first,
   output logic [SAMPLE_W-1:0] aligned
);

   int unsigned sh;
   logic [SAMPLE_W-1:0] keep_low, keep_high;

   always_comb begin
      sh        = SAMPLE_W - word_bits(wsel);
      keep_low  = {SAMPLE_W{1'b1}} >> sh;
      keep_high = {SAMPLE_W{1'b1}} << sh;
      // MSB-first words sit at the bottom of the window, LSB-first at the top
      if (lsb_first) aligned = word & keep_high;
      else           aligned = (word & keep_low) << sh;
   end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
   import sarx_pkg::*;
#(
   parameter int SAMPLE_W    = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                word_clk,
   input  logic                bit_clk,
   input  logic                ser_data,
   input  logic [1:0]          fmt_sel,
   input  logic                lsb_first,
   input  logic [1:0]          width_sel,
   output logic [SAMPLE_W-1:0] left_sample,
   output logic                left_valid,
   output logic [SAMPLE_W-1:0] right_sample,
   output logic                right_valid
);

   localparam int CNT_W = $clog2(SAMPLE_W + 2) + 1;

   if (SAMPLE_W < 24) begin : g_bad_width
      $error("serial_audio_rx: SAMPLE_W must hold a 24-bit word");
   end

   logic [2:0]          sync_q;
   logic                df_emit, df_left;
   logic [SAMPLE_W-1:0] df_word, aligned;

   sarx_sync #(.STAGES(SYNC_STAGES), .N(3)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({word_clk, bit_clk, ser_data}),
      .q     (sync_q)
   );

   sarx_deframe #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_deframe (
      .clk       (clk),
      .rst_n     (rst_n),
      .bclk      (sync_q[1]),
      .ws        (sync_q[2]),
      .sd        (sync_q[0]),
      .fmt       (fmt_sel),
      .lsb_first (lsb_first),
      .wsel      (width_sel),
      .emit      (df_emit),
      .emit_left (df_left),
      .word      (df_word)
   );

   sarx_align #(.SAMPLE_W(SAMPLE_W)) u_align (
      .word      (df_word),
      .wsel      (width_sel),
      .lsb_first (lsb_first),
      .aligned   (aligned)
   );

   for (genvar ch = 0; ch < 2; ch++) begin : g_ch
      localparam logic IS_LEFT = (ch == 0);
      logic [SAMPLE_W-1:0] d_r;
      logic                v_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_r <= '0;
            v_r <= 1'b0;
         end else begin
            v_r <= df_emit && (df_left == IS_LEFT);
            if (df_emit && (df_left == IS_LEFT)) d_r <= aligned;
         end
      end
   end

   assign left_sample  = g_ch[0].d_r;
   assign left_valid   = g_ch[0].v_r;
   assign right_sample = g_ch[1].d_r;
   assign right_valid  = g_ch[1].v_r;

   logic [SAMPLE_W-1:0] pad_mask;
   assign pad_mask = {SAMPLE_W{1'b1}} >> word_bits(width_sel);

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(left_valid && right_valid)) else $error("both strobes high"); // R8
   AST_LEFT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      left_valid |=> !left_valid) else $error("left strobe longer than one cycle"); // R8
   AST_RIGHT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      right_valid |=> !right_valid) else $error("right strobe longer than one cycle"); // R8
   AST_LEFT_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      left_valid |-> ((left_sample & pad_mask) == '0)) else $error("left padding not zero"); // R5
   AST_RIGHT_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      right_valid |-> ((right_sample & pad_mask) == '0)) else $error("right padding not zero"); // R5

endmodule

// File: tb/test_serial_audio_rx.sv
module test_serial_audio_rx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b0, ws = 1'b0, sd = 1'b0;
   logic [1:0]  fmt = 2'd0, wsel = 2'd0;
   logic        lsb = 1'b0;
   logic [23:0] left_sample, right_sample;
   logic        left_valid, right_valid;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;
   bit  glitch = 1'b0;

   typedef struct {
      bit          left;
      logic [23:0] data;
      string       req;
   } item_t;
   item_t exp_q[$];

   always #10 clk = ~clk;

   serial_audio_rx i_serial_audio_rx (
      .clk          (clk),
      .rst_n        (rst_n),
      .word_clk     (ws),
      .bit_clk      (bclk),
      .ser_data     (sd),
      .fmt_sel      (fmt),
      .lsb_first    (lsb),
      .width_sel    (wsel),
      .left_sample  (left_sample),
      .left_valid   (left_valid),
      .right_sample (right_sample),
      .right_valid  (right_valid)
   );

   function automatic int wbits(input logic [1:0] s);
      case (s)
         2'd0: return 24;
         2'd1: return 20;
         2'd2: return 18;
         default: return 16;
      endcase
   endfunction

   // monitor: pop expected items in order as strobes appear
   always @(negedge clk) begin
      item_t it;
      if (rst_n && (left_valid || right_valid)) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R9 unexpected strobe L=%0b R=%0b data=%h/%h expected none",
                     left_valid, right_valid, left_sample, right_sample);
         end else begin
            it = exp_q.pop_front();
            if (it.left != left_valid) begin
               errors++;
               $display("FAIL R8 %s channel order: got left=%0b expected left=%0b",
                        it.req, left_valid, it.left);
            end else if ((it.left ? left_sample : right_sample) != it.data) begin
               errors++;
               $display("FAIL %s R5 R6 data: got %h expected %h", it.req,
                        it.left ? left_sample : right_sample, it.data);
            end
         end
      end
   end

   task automatic bit_slot(input logic wsv, input logic sdv);
      @(negedge clk);
      bclk = 1'b0; ws = wsv; sd = sdv;
      repeat (4) @(negedge clk);
      bclk = 1'b1;
      repeat (2) @(negedge clk);
      if (glitch) sd = ~sd;   // R7: change while clock is high
      repeat (2) @(negedge clk);
   endtask

   function automatic logic left_level();
      return (fmt == 2'd0) ? 1'b0 : 1'b1;
   endfunction

   task automatic send_half(input bit is_left, input logic [23:0] val, input string req);
      int w = wbits(wsel);
      logic [23:0] wd = val >> (24 - w);
      logic wsv = is_left ? left_level() : ~left_level();
      item_t it;
      it.left = is_left;
      it.data = val & ~((24'd1 << (24 - w)) - 24'd1);
      it.req  = req;
      exp_q.push_back(it);
      for (int slot = 0; slot < 32; slot++) begin
         int  j;
         logic b;
         if (fmt == 2'd0)      j = slot - 1;
         else if (fmt == 2'd1) j = slot;
         else                  j = slot - (32 - w);
         if (j >= 0 && j < w) b = lsb ? wd[j] : wd[w-1-j];
         else                 b = 1'b1;
         bit_slot(wsv, b);
      end
   endtask

   task automatic run_case(input logic [1:0] f, input logic order, input logic [1:0] ws_code,
                           input bit gl, input string req);
      rst_n = 1'b0;
      fmt = f; lsb = order; wsel = ws_code; glitch = gl;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // preamble at the right-channel level: partial word, must give nothing (R9)
      for (int k = 0; k < 5; k++) bit_slot(~left_level(), 1'b1);
      send_half(1'b1, 24'h800000, req); send_half(1'b0, 24'h7FFFFF, req);
      send_half(1'b1, 24'h123456, req); send_half(1'b0, 24'hFEDCBA, req);
      send_half(1'b1, 24'hA5C3E1, req); send_half(1'b0, 24'h0000FF, req);
      for (int k = 0; k < 3; k++) bit_slot(left_level(), 1'b0);
      repeat (12) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R8 %s samples missing: got %0d pending expected 0", req, exp_q.size());
         exp_q.delete();
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (left_sample !== 24'd0 || right_sample !== 24'd0 || left_valid !== 1'b0 || right_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset state: got %h %h %b %b expected 0 0 0 0",
                  left_sample, right_sample, left_valid, right_valid);
      end
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      checks++;
      if (left_valid !== 1'b0 || right_valid !== 1'b0 || left_sample !== 24'd0) begin
         errors++;
         $display("FAIL R1 idle after reset: got %b %b %h expected 0 0 0",
                  left_valid, right_valid, left_sample);
      end
      run_case(2'd0, 1'b0, 2'd0, 1'b0, "R2");
      run_case(2'd1, 1'b0, 2'd1, 1'b0, "R3");
      run_case(2'd2, 1'b0, 2'd3, 1'b0, "R4");
      run_case(2'd0, 1'b1, 2'd2, 1'b0, "R2");
      run_case(2'd1, 1'b1, 2'd0, 1'b0, "R3");
      run_case(2'd2, 1'b1, 2'd1, 1'b1, "R4 R7");
      run_case(2'd2, 1'b0, 2'd0, 1'b0, "R4");
      run_case(2'd1, 1'b0, 2'd3, 1'b1, "R3 R7");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired: got running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule